// File: doc/BRIEF.md
# Nibble Accumulator Execution Unit

This block owns a 4-bit accumulator and a single carry flag and carries out every operation that alters either of them. Each cycle in which the execute strobe is high, it takes an already-fetched 8-bit opcode and a 4-bit operand, and registers the new accumulator and carry at the next clock edge. The operand comes from an index register or from data memory. The same strobe also produces a write-back nibble for the two operations that modify an index register: exchange with the accumulator, and increment.

Most operations are arithmetic: binary add and subtract with carry, accumulator increment and decrement, and rotation through carry. The rest handle the flag and code conversion: clearing and complementing, carry transfer into the accumulator, decimal correction after a BCD add, and conversion of a one-hot key code to its position. Each instruction class updates the carry by its own rule, not by a shared ALU flag. Fetch, index-register storage and memory are outside the block. The surrounding core supplies the operand and stores the write-back nibble in the same cycle as the strobe.

Top module: `nau_core`

## Requirements
- R1: After the active-low reset, the accumulator and carry are 0 and the write-back enable is low.
- R2: Opcodes 0x80 to 0x8F (register add) and 0xEB (memory add) set the accumulator to the low 4 bits of A + operand + carry, and set the carry to bit 4 of that 5-bit sum.
- R3: Opcodes 0x90 to 0x9F (register subtract) and 0xE8 (memory subtract) take the 5-bit two's-complement result of A − operand − carry. The accumulator gets the low 4 bits of that result and the carry gets bit 4, so the carry is 1 exactly when a borrow occurs.
- R4: 0xF2 increments A and sets the carry only when A was 15. 0xF8 decrements A and sets the carry only when A was 0.
- R5: 0xF5 rotates the 5-bit value {carry, A} left, so the old carry enters A bit 0 and the old A bit 3 becomes the carry. 0xF6 rotates it right, so the old carry enters A bit 3 and the old A bit 0 becomes the carry.
- R6: For 0xFB, when A > 9 or the carry is set, A becomes the low 4 bits of A + 6 and the carry becomes bit 4 of that sum. Otherwise A and the carry are unchanged.
- R7: 0xFC maps A values 0, 1, 2, 4 and 8 to 0, 1, 2, 3 and 4, and maps every other value to 15. The carry is unchanged.
- R8: 0xF0 clears both A and the carry. 0xF7 loads the carry into A and clears the carry. 0xF9 loads 9 + carry into A and clears the carry.
- R9: 0xF1 clears the carry, 0xFA sets it and 0xF3 inverts it, and none of these touch A. 0xF4 inverts A and leaves the carry unchanged.
- R10: 0xA0 to 0xAF load the operand into A, and 0xD0 to 0xDF load the opcode's low nibble into A. The carry is unchanged in both cases.
- R11: 0xB0 to 0xBF load the operand into A and leave the carry unchanged. In the same cycle they raise the write-back enable with the old A on the write-back data.
- R12: 0x60 to 0x6F raise the write-back enable with the operand + 1 (mod 16) on the write-back data, and leave A and the carry unchanged.
- R13: Every other opcode, and any cycle with the execute strobe low, leaves A and the carry unchanged and keeps the write-back enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe; the opcode takes effect at the next clock edge |
| opcode_i | input | 8 | Decoded instruction byte |
| operand_i | input | 4 | Index register or memory nibble |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry flag |
| wb_en_o | output | 1 | Index register write-back enable |
| wb_data_o | output | 4 | Index register write-back value |

## Verification
The exchange opcodes are the case where two functions fall in the same cycle. The accumulator loads the operand at the clock edge, while the combinational write-back output must still carry the accumulator value from before that edge. The bench provokes this by preloading every accumulator value, with both carry states, before an exchange with every operand. It samples the write-back nibble just before the edge and the accumulator just after it, and compares each against its own arithmetic model. The increment opcodes are swept in the same way, and the bench checks that the accumulator is left unchanged while the write-back nibble changes.

// File: rtl/nau_pkg.sv
package nau_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned OPC_W = 8;
  localparam int unsigned EXT_W = NIB_W + 1;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_LD, OP_XCH, OP_LDM, OP_INCR,
    OP_CLB, OP_CLC, OP_IAC, OP_CMC, OP_CMA, OP_RAL, OP_RAR,
    OP_TCC, OP_DAC, OP_TCS, OP_STC, OP_DAA, OP_KBP
  } op_e;
endpackage

// File: rtl/nau_decode.sv
module nau_decode
  import nau_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output op_e              op_o
);
  always_comb begin
    op_o = OP_NONE;
    unique case (opcode_i[7:4])
      4'h6: op_o = OP_INCR;
      4'h8: op_o = OP_ADD;
      4'h9: op_o = OP_SUB;
      4'hA: op_o = OP_LD;
      4'hB: op_o = OP_XCH;
      4'hD: op_o = OP_LDM;
      4'hE: begin
        if (opcode_i[3:0] == 4'h8) op_o = OP_SUB;
        else if (opcode_i[3:0] == 4'hB) op_o = OP_ADD;
      end
      4'hF: begin
        unique case (opcode_i[3:0])
          4'h0: op_o = OP_CLB;
          4'h1: op_o = OP_CLC;
          4'h2: op_o = OP_IAC;
          4'h3: op_o = OP_CMC;
          4'h4: op_o = OP_CMA;
          4'h5: op_o = OP_RAL;
          4'h6: op_o = OP_RAR;
          4'h7: op_o = OP_TCC;
          4'h8: op_o = OP_DAC;
          4'h9: op_o = OP_TCS;
          4'hA: op_o = OP_STC;
          4'hB: op_o = OP_DAA;
          4'hC: op_o = OP_KBP;
          default: op_o = OP_NONE;
        endcase
      end
      default: op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/nau_alu.sv
module nau_alu
  import nau_pkg::*;
(
  input  op_e              op_i,
  input  logic [NIB_W-1:0] a_i,
  input  logic             c_i,
  input  logic [NIB_W-1:0] b_i,
  input  logic [NIB_W-1:0] imm_i,
  output logic [NIB_W-1:0] a_o,
  output logic             c_o
);
  localparam logic [NIB_W-1:0] DEC_MAX = NIB_W'(9);
  localparam logic [NIB_W-1:0] DEC_ADJ = NIB_W'(6);
  localparam logic [NIB_W-1:0] ALL_ONE = '1;

  logic [EXT_W-1:0] sum, diff, inc, dec, adj;
  logic [NIB_W-1:0] kbp;

  assign sum  = {1'b0, a_i} + {1'b0, b_i} + EXT_W'(c_i);
  assign diff = {1'b0, a_i} - {1'b0, b_i} - EXT_W'(c_i);
  assign inc  = {1'b0, a_i} + EXT_W'(1);
  assign dec  = {1'b0, a_i} - EXT_W'(1);
  assign adj  = {1'b0, a_i} + {1'b0, DEC_ADJ};

  // one-hot key position, anything else is an error code
  always_comb begin
    kbp = ALL_ONE;
    if (a_i == '0) kbp = '0;
    else if ($countones(a_i) == 1)
      for (int i = 0; i < NIB_W; i++)
        if (a_i[i]) kbp = NIB_W'(i + 1);
  end

  always_comb begin
    a_o = a_i;
    c_o = c_i;
    unique case (op_i)
      OP_ADD: {c_o, a_o} = sum;
      OP_SUB: {c_o, a_o} = diff;
      OP_LD, OP_XCH: a_o = b_i;
      OP_LDM: a_o = imm_i;
      OP_CLB: begin a_o = '0; c_o = 1'b0; end
      OP_CLC: c_o = 1'b0;
      OP_STC: c_o = 1'b1;
      OP_CMC: c_o = ~c_i;
      OP_CMA: a_o = ~a_i;
      OP_IAC: {c_o, a_o} = inc;
      OP_DAC: {c_o, a_o} = dec;
      OP_RAL: {c_o, a_o} = {a_i, c_i};
      OP_RAR: {a_o, c_o} = {c_i, a_i};
      OP_TCC: begin a_o = NIB_W'(c_i); c_o = 1'b0; end
      OP_TCS: begin a_o = DEC_MAX + NIB_W'(c_i); c_o = 1'b0; end
      OP_DAA: if (a_i > DEC_MAX || c_i) {c_o, a_o} = adj;
      OP_KBP: a_o = kbp;
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == OP_KBP)
      p_kbp_code_r7: assert (a_o <= NIB_W'(4) || a_o == ALL_ONE);
  end
endmodule

// File: rtl/nau_core.sv
module nau_core
  import nau_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_i,
  input  logic [7:0]       opcode_i,
  input  logic [3:0]       operand_i,
  output logic [3:0]       acc_o,
  output logic             carry_o,
  output logic             wb_en_o,
  output logic [3:0]       wb_data_o
);
  op_e              op;
  logic [NIB_W-1:0] acc_q, acc_d;
  logic             cy_q, cy_d;

  nau_decode u_dec (
    .opcode_i (opcode_i),
    .op_o     (op)
  );

  nau_alu u_alu (
    .op_i  (op),
    .a_i   (acc_q),
    .c_i   (cy_q),
    .b_i   (operand_i),
    .imm_i (opcode_i[NIB_W-1:0]),
    .a_o   (acc_d),
    .c_o   (cy_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (exec_i) begin
      acc_q <= acc_d;
      cy_q  <= cy_d;
    end
  end

  // write-back leaves before the accumulator edge, so XCH sees the old value
  assign wb_en_o   = exec_i && (op == OP_XCH || op == OP_INCR);
  assign wb_data_o = (op == OP_XCH) ? acc_q : operand_i + NIB_W'(1);
  assign acc_o     = acc_q;
  assign carry_o   = cy_q;

  p_idle_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(acc_o) && $stable(carry_o));
  p_wb_needs_exec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> exec_i);
  p_inc_keeps_state_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && opcode_i[7:4] == 4'h6 |=> $stable(acc_o) && $stable(carry_o));
  p_clb_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && opcode_i == 8'hF0 |=> acc_o == '0 && !carry_o);
  p_tcs_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && opcode_i == 8'hF9 |=> (acc_o == 4'd9 || acc_o == 4'd10) && !carry_o);
  p_xch_takes_operand_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && opcode_i[7:4] == 4'hB |=> acc_o == $past(operand_i) && $stable(carry_o));
endmodule

// File: tb/sim_nau_core.sv
module sim_nau_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [3:0] operand = 4'h0;
  logic [3:0] acc;
  logic       carry, wb_en;
  logic [3:0] wb_data;
  int tests = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  nau_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .opcode_i(opcode),
    .operand_i(operand), .acc_o(acc), .carry_o(carry),
    .wb_en_o(wb_en), .wb_data_o(wb_data)
  );

  // {wb_en, wb[3:0], carry, acc[3:0]}
  function automatic logic [9:0] model(input logic [7:0] op, input logic [3:0] a,
                                       input logic c, input logic [3:0] b);
    int ra = a, rc = c, v;
    int we = 0, wv = 0;
    case (op[7:4])
      4'h6: begin we = 1; wv = (b + 1) % 16; end
      4'h8: begin v = a + b + c; ra = v % 16; rc = v / 16; end
      4'h9: begin v = (a - b - c + 32) % 32; ra = v % 16; rc = v / 16; end
      4'hA: ra = b;
      4'hB: begin we = 1; wv = a; ra = b; end
      4'hD: ra = op[3:0];
      default: ;
    endcase
    if (op == 8'hEB) begin v = a + b + c; ra = v % 16; rc = v / 16; end
    if (op == 8'hE8) begin v = (a - b - c + 32) % 32; ra = v % 16; rc = v / 16; end
    case (op)
      8'hF0: begin ra = 0; rc = 0; end
      8'hF1: rc = 0;
      8'hF2: begin ra = (a + 1) % 16; rc = (a == 15); end
      8'hF3: rc = 1 - c;
      8'hF4: ra = 15 - a;
      8'hF5: begin ra = (a * 2 + c) % 16; rc = a / 8; end
      8'hF6: begin ra = a / 2 + 8 * c; rc = a % 2; end
      8'hF7: begin ra = c; rc = 0; end
      8'hF8: begin ra = (a + 15) % 16; rc = (a == 0); end
      8'hF9: begin ra = 9 + c; rc = 0; end
      8'hFA: rc = 1;
      8'hFB: if (a > 9 || c) begin ra = (a + 6) % 16; rc = (a + 6) / 16; end
      8'hFC: case (a)
               0: ra = 0; 1: ra = 1; 2: ra = 2; 4: ra = 3; 8: ra = 4;
               default: ra = 15;
             endcase
      default: ;
    endcase
    return {1'(we), 4'(wv), 1'(rc), 4'(ra)};
  endfunction

  function automatic string tag(input logic [7:0] op);
    case (op[7:4])
      4'h6: return "R12"; 4'h8: return "R2"; 4'h9: return "R3";
      4'hA, 4'hD: return "R10"; 4'hB: return "R11";
      default: ;
    endcase
    case (op)
      8'hEB: return "R2"; 8'hE8: return "R3";
      8'hF2, 8'hF8: return "R4"; 8'hF5, 8'hF6: return "R5";
      8'hFB: return "R6"; 8'hFC: return "R7";
      8'hF0, 8'hF7, 8'hF9: return "R8";
      8'hF1, 8'hFA, 8'hF3, 8'hF4: return "R9";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input logic [7:0] op, input logic [3:0] b,
                      output logic we, output logic [3:0] wv);
    exec = 1'b1; opcode = op; operand = b;
    #1;
    we = wb_en; wv = wb_data;
    @(negedge clk);
  endtask

  task automatic run(input logic [7:0] op, input logic [3:0] a, input logic c, input logic [3:0] b);
    logic we; logic [3:0] wv;
    logic [9:0] e;
    step({4'hD, a}, 4'h0, we, wv);
    step(c ? 8'hFA : 8'hF1, 4'h0, we, wv);
    e = model(op, a, c, b);
    step(op, b, we, wv);
    exec = 1'b0;
    check(tag(op), "acc", acc, e[3:0]);
    check(tag(op), "carry", carry, e[4]);
    check(tag(op), "wb_en", we, e[9]);
    if (e[9]) check(tag(op), "wb_data", wv, e[8:5]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic we; logic [3:0] wv;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", "acc", acc, 0);
    check("R1", "carry", carry, 0);
    check("R1", "wb_en", wb_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "acc after release", acc, 0);

    // R2 R3 R10 R11 register forms, all A, carry, operand
    for (int hi = 8; hi <= 11; hi++)
      for (int a = 0; a < 16; a++)
        for (int c = 0; c < 2; c++)
          for (int b = 0; b < 16; b++)
            run(8'(hi * 16 + b), 4'(a), 1'(c), 4'(b));
    // R2 R3 memory forms
    for (int a = 0; a < 16; a++)
      for (int c = 0; c < 2; c++)
        for (int b = 0; b < 16; b++) begin
          run(8'hEB, 4'(a), 1'(c), 4'(b));
          run(8'hE8, 4'(a), 1'(c), 4'(b));
        end
    // R4..R9 single-byte group, all A and carry
    for (int op = 8'hF0; op <= 8'hFF; op++)
      for (int a = 0; a < 16; a++)
        for (int c = 0; c < 2; c++)
          run(8'(op), 4'(a), 1'(c), 4'(a ^ 5));
    // R12 index increment wraps, R10 immediate load
    for (int b = 0; b < 16; b++)
      for (int c = 0; c < 2; c++) begin
        run(8'(8'h60 + b), 4'(15 - b), 1'(c), 4'(b));
        run(8'(8'hD0 + b), 4'(b ^ 9), 1'(c), 4'(3));
      end
    // R13 every opcode once against the model
    for (int op = 0; op < 256; op++)
      run(8'(op), 4'h7, 1'b1, 4'hC);
    // R13 strobe low ignores an opcode that would clear
    step(8'hD6, 4'h0, we, wv);
    step(8'hFA, 4'h0, we, wv);
    exec = 1'b0; opcode = 8'hF0; operand = 4'h2;
    #1 check("R13", "wb_en idle", wb_en, 0);
    @(negedge clk);
    check("R13", "acc idle", acc, 6);
    check("R13", "carry idle", carry, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule